// File: doc/BRIEF.md
# Transmit-Only Serial Peripheral Master

This block sends 12-bit words to a single serial slave over three wires: an active-low select, a serial clock and a data line from master to slave. There is no return data line. A one-cycle send strobe captures the word presented on the parallel input and starts a frame. The frame shifts the word out most significant bit first, and the serial clock runs at one twentieth of the system clock during the frame.

The serial clock idles low. The data line changes only when the serial clock falls, so it is stable at every rising edge, where the slave samples it. After the twelfth falling edge the block raises the select, forces the data line low and returns to idle. It accepts a new strobe one cycle after that. Strobes that arrive during a frame are ignored.

The reset input is asserted asynchronously and released synchronously inside the block. While reset is asserted, the block is idle.

Top module: `spi_tx_master`

## Requirements
- R1: While reset is asserted, csn_o is 1, sclk_o is 0 and mosi_o is 0, including when reset arrives in the middle of a frame.
- R2: A send_i level of 1 sampled at a clock edge while idle captures word_i and drives csn_o to 0 from that edge on. csn_o then stays 0 for exactly 240 clock cycles (2 x 10 x 12).
- R3: During a frame, sclk_o is 0 for the first 10 cycles. It then alternates with 10 cycles high and 10 cycles low, giving 12 high pulses in the frame.
- R4: Whenever csn_o is 1, sclk_o is 0.
- R5: The bits go out most significant bit first. Bit word[11-b] is on mosi_o for frame cycles 20b through 20b+19, where frame cycle 0 is the first cycle with csn_o at 0.
- R6: mosi_o never changes in a cycle in which sclk_o is 1, so it is unchanged across every rising edge of sclk_o.
- R7: A send_i pulse, or a change on word_i, during a frame has no effect on that frame. This includes a pulse sampled at the edge that ends the frame.
- R8: Whenever csn_o is 1, mosi_o is 0.
- R9: A send_i pulse sampled at the first edge after a frame ends starts the next frame at once, with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously |
| send_i | input | 1 | Send strobe that captures word_i and starts a frame when idle |
| word_i | input | 12 | Parallel word to transmit |
| csn_o | output | 1 | Active-low slave select |
| sclk_o | output | 1 | Serial clock, system clock divided by 20, idles low |
| mosi_o | output | 1 | Serial data from master to slave |

## Verification
Each output is due a fixed number of edges after the send strobe is sampled. The select falls at that edge. The serial clock rises 10 edges later and then toggles every 10 edges. Each data bit appears 20 edges after the one before it, and the block is idle again 240 edges after the strobe. The bench drives inputs on falling clock edges and counts frame cycles from the edge that sampled the strobe. At every falling edge it compares all three outputs with values it computes from that cycle number and the word. It sweeps walking-one, walking-zero, extreme and stepped words back to back. A separate frame injects a stray strobe mid-frame and at the edge that ends the frame, and another asserts reset mid-frame.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_e;

endpackage

// File: rtl/spi_tx_rst_sync.sv
module spi_tx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/spi_tx_clkgen.sv
module spi_tx_clkgen #(
  parameter int HALF_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_tick_o
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          tick;
  logic          en;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (run_i) begin
      if (tick) begin
        cnt_d  = '0;
        sclk_d = ~sclk_q;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end else begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end
  end

  assign en = run_i | sclk_q | (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o      = sclk_q;
  assign fall_tick_o = run_i & tick & sclk_q;

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              clear_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              mosi_o
);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic              en;

  always_comb begin
    sr_d = sr_q;
    if (load_i) begin
      sr_d = word_i;
    end else if (clear_i) begin
      sr_d = '0;
    end else if (shift_i) begin
      sr_d = {sr_q[WORD_W-2:0], 1'b0};
    end
  end

  assign en = load_i | shift_i | clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (en) begin
      sr_q <= sr_d;
    end
  end

  assign mosi_o = sr_q[WORD_W-1];

endmodule

// File: rtl/spi_tx_ctrl.sv
module spi_tx_ctrl
  import spi_tx_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic send_i,
  input  logic fall_tick_i,
  output logic load_o,
  output logic shift_o,
  output logic clear_o,
  output logic run_o,
  output logic csn_o
);

  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  tx_state_e     state_q, state_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          bit_en;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    clear_o = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (send_i) begin
          load_o  = 1'b1;
          bit_d   = '0;
          state_d = TX_SHIFT;
        end
      end
      TX_SHIFT: begin
        if (fall_tick_i) begin
          if (bit_q == LAST_BIT) begin
            clear_o = 1'b1;
            bit_d   = '0;
            state_d = TX_IDLE;
          end else begin
            shift_o = 1'b1;
            bit_d   = bit_q + 1'b1;
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  assign bit_en = load_o | fall_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
    end else if (bit_en) begin
      bit_q <= bit_d;
    end
  end

  assign run_o = (state_q == TX_SHIFT);
  assign csn_o = (state_q != TX_SHIFT);

endmodule

// File: rtl/spi_tx_master.sv
module spi_tx_master #(
  parameter int WORD_W   = 12,
  parameter int HALF_DIV = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              csn_o,
  output logic              sclk_o,
  output logic              mosi_o
);

  logic rst_sync_n;
  logic load, shift, clear, run, fall_tick;

  spi_tx_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  spi_tx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .send_i      (send_i),
    .fall_tick_i (fall_tick),
    .load_o      (load),
    .shift_o     (shift),
    .clear_o     (clear),
    .run_o       (run),
    .csn_o       (csn_o)
  );

  spi_tx_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .run_i       (run),
    .sclk_o      (sclk_o),
    .fall_tick_o (fall_tick)
  );

  spi_tx_shifter #(.WORD_W(WORD_W)) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .load_i  (load),
    .shift_i (shift),
    .clear_i (clear),
    .word_i  (word_i),
    .mosi_o  (mosi_o)
  );

endmodule

// File: rtl/spi_tx_master_chk.sv
module spi_tx_master_chk #(
  parameter int WORD_W   = 12,
  parameter int HALF_DIV = 10
) (
  input logic clk,
  input logic rst_n,
  input logic send,
  input logic csn,
  input logic sclk,
  input logic mosi
);

  localparam int FRAME = 2 * HALF_DIV * WORD_W;
  localparam int LW    = $clog2(HALF_DIV + 2);
  localparam int FW    = $clog2(FRAME + 2);

  logic [LW-1:0] len_q;
  logic [FW-1:0] frm_q;
  logic          sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q       <= '0;
      frm_q       <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk;
      if (csn) begin
        len_q <= '0;
      end else if (sclk != sclk_prev_q) begin
        len_q <= LW'(1);
      end else if (len_q <= LW'(HALF_DIV)) begin
        len_q <= len_q + 1'b1;
      end
      if (csn) begin
        frm_q <= '0;
      end else if (frm_q <= FW'(FRAME)) begin
        frm_q <= frm_q + 1'b1;
      end
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && send) |=> !csn);

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn) |-> (frm_q == FW'(FRAME)));

  assert_half_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && (sclk != sclk_prev_q)) |-> (len_q == LW'(HALF_DIV)));

  assert_half_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !csn |-> (len_q <= LW'(HALF_DIV)));

  assert_idle_sclk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !sclk);

  assert_mosi_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && send && (frm_q < FW'(FRAME - 1))) |=> !csn);

  assert_idle_mosi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !mosi);

endmodule

bind spi_tx_master spi_tx_master_chk #(
  .WORD_W   (WORD_W),
  .HALF_DIV (HALF_DIV)
) u_chk (
  .clk   (clk_i),
  .rst_n (rst_sync_n),
  .send  (send_i),
  .csn   (csn_o),
  .sclk  (sclk_o),
  .mosi  (mosi_o)
);

// File: tb/sim_spi_tx_master.sv
`timescale 1ns/1ps
module sim_spi_tx_master;

  localparam int W     = 12;
  localparam int HD    = 10;
  localparam int FRAME = 2 * HD * W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         send_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         csn_o, sclk_o, mosi_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk_i = ~clk_i;

  spi_tx_master #(.WORD_W(W), .HALF_DIV(HD)) u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .send_i (send_i),
    .word_i (word_i),
    .csn_o  (csn_o),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk({tag, " csn"},  int'(csn_o),  1);
    chk({tag, " sclk"}, int'(sclk_o), 0);
    chk({tag, " mosi"}, int'(mosi_o), 0);
  endtask

  // Runs one frame; on return we stand at the negedge of frame cycle FRAME (idle).
  // stray: 0 none, 1 strobe + word change mid-frame, 2 strobe sampled at the ending edge
  task automatic frame(input logic [W-1:0] w, input int stray);
    word_i = w;
    send_i = 1'b1;
    @(negedge clk_i);
    send_i = 1'b0;
    for (int k = 0; k < FRAME; k++) begin
      // R2, R3, R5: expected outputs from frame cycle number
      chk("R2 csn low",  int'(csn_o),  0);
      chk("R3 sclk",     int'(sclk_o), (k / HD) % 2);
      chk("R5 msb-first", int'(mosi_o), int'(w[W-1-(k/(2*HD))]));
      if (stray == 1 && k == 57) begin word_i = ~w; send_i = 1'b1; end
      else if (stray == 1 && k == 58) send_i = 1'b0;
      else if (stray == 2 && k == FRAME - 1) send_i = 1'b1;
      @(negedge clk_i);
    end
    send_i = 1'b0;
    idle_chk("R2 end R4 R8");
    if (stray == 2) begin
      @(negedge clk_i);
      idle_chk("R7 end strobe ignored");
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    idle_chk("R1 reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    idle_chk("R4 R8 idle");

    // Walking ones and zeros, extremes, stepped words, back to back (R9)
    for (int i = 0; i < W; i++) frame(W'(1) << i, 0);
    for (int i = 0; i < W; i++) frame(~(W'(1) << i), 0);
    frame('0, 0);
    frame('1, 0);
    for (int i = 0; i < 16; i++) frame(W'((i * 1237 + 91) % (1 << W)), 0);

    // R9 back-to-back: frame() returns at idle; next strobe sampled at first edge after end
    frame(12'hA5A, 0);
    frame(12'h5A5, 0);

    // R7 stray strobe and word change during frame
    frame(12'hC3C, 1);
    frame(12'h3C3, 2);
    frame(12'h81F, 0);

    // R1 reset mid-frame
    word_i = 12'hFFF;
    send_i = 1'b1;
    @(negedge clk_i);
    send_i = 1'b0;
    repeat (100) @(negedge clk_i);
    chk("R1 pre-reset busy", int'(csn_o), 0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    idle_chk("R1 mid-frame reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    idle_chk("R1 after release");
    frame(12'h9E7, 0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk_i);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule